// File: doc/BRIEF.md
# Double-Buffered PWM Generator with Fault Shutdown

This block is one PWM channel. An up-counter sets the period. It drives a complementary output pair and a third, independent output, and each output has its own compare value. Software writes the period and the compare values through a simple register port into shadow copies. Those copies reach the working registers only at a reload point. A reload point is the end of every Nth period, where N runs from 1 to 16. It can also be the middle of a period, if that option is enabled. A reload also needs software to arm it first. Each reload disarms it, so every change is applied exactly once and never part-way through a pulse.

Up to eight fault lines enter through glitch filters. Each filter has a common, programmable hold length. Each fault line can be routed to the output pair, to the third output, or to both. A recognised fault holds the routed outputs at their inactive level. They stay there until software clears the latched fault and the counter then reaches a period boundary. Output polarity and a per-output software override are staged in shadow registers. A single force strobe moves them into use, so all three outputs switch on the same clock edge.

Top module: `pwm_fault_gen`

## Requirements
- R1: The active period and compare values change only at a reload point. Every pulse is therefore a whole pulse of either the old setting or the new one.
- R2: The reload field is register 3 bits [3:0] and holds N-1. Full-period reload points fall exactly N periods apart.
- R3: When register 3 bit 8 is set, the midpoint of the period is also a reload point. The midpoint is the count value floor(P/2). A compare change therefore takes effect in the second half of the same period.
- R4: Register 4 arms a reload when written. With no arm, shadow writes never reach the outputs. Each reload clears the arm.
- R5: Register 0 holds P, and a period lasts P+1 clocks with the count running 0..P. Output A is high while count < DA, and DA is register 1. Output B is the complement of A. Output X is high while count < DX, and DX is register 2.
- R6: A fault line is recognised only after it has been high for F+1 consecutive clocks. F is register 8 bits [2:0]. Shorter pulses have no effect.
- R7: Register 7 routes the faults. Bits [7:0] route fault lines to the A/B pair and bits [15:8] route them to X. A recognised routed fault drives those outputs to their inactive level, which is the polarity bit. Outputs not routed to the fault keep running.
- R8: The safe state persists after the fault line drops. It is released only after a write of 1 to the fault's bit in register 9 clears it, and then only at the next period boundary. The first pulse after release is whole.
- R9: Register 5 bits [2:0] invert outputs A, B and X. The inversion takes effect only at a force strobe.
- R10: Register 6 bits [2:0] enable a software override for A, B and X, and bits [6:4] give the override levels. The override takes effect only at a force strobe.
- R11: A force strobe applies the staged polarity and override to all three outputs at the same edge.
- R12: In reset all outputs are low and the active registers are zero. After reset, A and X are low and B is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register address |
| wrData | input | 16 | Register write data |
| faultIn | input | 8 | Fault lines, active high |
| forceStrobe | input | 1 | Applies staged polarity and override |
| outA | output | 1 | Primary PWM output |
| outB | output | 1 | Complementary PWM output |
| outX | output | 1 | Independent third PWM output |

## Verification
The bound checker watches several rules on every cycle:
- the active compare value moves only in a cycle that follows a load strobe;
- outputs in the safe state sit at their polarity level, and the safe state ends only at a period end;
- staged settings move only after a force strobe;
- the pair stays complementary whenever nothing overrides it.

Other properties depend on how events line up in time, and only the directed scenarios can show them:
- the reload spacing of exactly N periods;
- the mid-period second pulse produced by a midpoint reload;
- the filter rejecting a pulse one clock too short;
- the release of the safe state on a whole pulse.

// File: rtl/pwm_fg_pkg.sv
package pwm_fg_pkg;

  // register map of the write port
  typedef enum logic [3:0] {
    REG_PERIOD = 4'd0,
    REG_DUTY_A = 4'd1,
    REG_DUTY_X = 4'd2,
    REG_RELOAD = 4'd3,
    REG_ARM    = 4'd4,
    REG_POL    = 4'd5,
    REG_OVR    = 4'd6,
    REG_FMASK  = 4'd7,
    REG_FILT   = 4'd8,
    REG_FCLR   = 4'd9
  } regAddr_t;

  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int CH_X   = 2;
  localparam int NUM_CH = 3;

  localparam int HALF_BIT   = 8;  // reload register: midpoint enable
  localparam int OVR_VAL_LO = 4;  // override register: first level bit
  localparam int XMASK_LO   = 8;  // fault mask register: first X bit

  // strobes from control to datapath
  typedef struct packed {
    logic loadAct;
    logic applyForce;
    logic blockPair;
    logic blockX;
  } dpStrobe_t;

endpackage

// File: rtl/pwm_fg_filter.sv
module pwm_fg_filter #(
  parameter int FILT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleIn,
  input  logic [FILT_W-1:0] holdCfg,
  output logic              detect
);

  localparam logic [FILT_W-1:0] RUN_MAX = {FILT_W{1'b1}};

  // number of consecutive high samples seen before this one
  logic [FILT_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (!sampleIn) begin
      runLen <= '0;
    end else if (runLen != RUN_MAX) begin
      runLen <= runLen + 1'b1;
    end
  end

  assign detect = sampleIn && (runLen >= holdCfg);

endmodule

// File: rtl/pwm_fg_ctrl.sv
module pwm_fg_ctrl
  import pwm_fg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 16,
  parameter int NUM_FAULTS = 8,
  parameter int FILT_W     = 3,
  parameter int RATE_W     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [3:0]            wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_FAULTS-1:0] faultIn,
  input  logic                  forceStrobe,
  input  logic                  periodEnd,
  input  logic                  halfPoint,
  output dpStrobe_t             strb,
  output logic [CNT_W-1:0]      periodSh,
  output logic [CNT_W-1:0]      dutyASh,
  output logic [CNT_W-1:0]      dutyXSh,
  output logic [NUM_CH-1:0]     polSh,
  output logic [NUM_CH-1:0]     swEnSh,
  output logic [NUM_CH-1:0]     swValSh
);

  logic [RATE_W-1:0]     rateCfg;
  logic                  halfEn;
  logic                  armed;
  logic [RATE_W-1:0]     reloadCnt;
  logic [NUM_FAULTS-1:0] maskPair;
  logic [NUM_FAULTS-1:0] maskX;
  logic [FILT_W-1:0]     filtCfg;
  logic [NUM_FAULTS-1:0] faultLat;
  logic [NUM_FAULTS-1:0] faultDet;
  logic [NUM_FAULTS-1:0] clrMask;
  logic                  blockPair;
  logic                  blockX;
  logic                  fullPoint;
  logic                  loadNow;
  logic                  pairHit;
  logic                  xHit;

  function automatic logic wrHit(input regAddr_t a);
    return wrEn && (wrAddr == a);
  endfunction

  // fault glitch filters, one per line
  for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_filt
    pwm_fg_filter #(.FILT_W(FILT_W)) filt_i (
      .clk     (clk),
      .rstN    (rstN),
      .sampleIn(faultIn[f]),
      .holdCfg (filtCfg),
      .detect  (faultDet[f])
    );
  end

  // configuration and shadow registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodSh <= '0;
      dutyASh  <= '0;
      dutyXSh  <= '0;
      rateCfg  <= '0;
      halfEn   <= 1'b0;
      polSh    <= '0;
      swEnSh   <= '0;
      swValSh  <= '0;
      maskPair <= '0;
      maskX    <= '0;
      filtCfg  <= '0;
    end else begin
      if (wrHit(REG_PERIOD)) periodSh <= wrData[CNT_W-1:0];
      if (wrHit(REG_DUTY_A)) dutyASh  <= wrData[CNT_W-1:0];
      if (wrHit(REG_DUTY_X)) dutyXSh  <= wrData[CNT_W-1:0];
      if (wrHit(REG_RELOAD)) begin
        rateCfg <= wrData[RATE_W-1:0];
        halfEn  <= wrData[HALF_BIT];
      end
      if (wrHit(REG_POL)) polSh <= wrData[NUM_CH-1:0];
      if (wrHit(REG_OVR)) begin
        swEnSh  <= wrData[NUM_CH-1:0];
        swValSh <= wrData[OVR_VAL_LO +: NUM_CH];
      end
      if (wrHit(REG_FMASK)) begin
        maskPair <= wrData[NUM_FAULTS-1:0];
        maskX    <= wrData[XMASK_LO +: NUM_FAULTS];
      end
      if (wrHit(REG_FILT)) filtCfg <= wrData[FILT_W-1:0];
    end
  end

  // reload scheduling
  assign fullPoint = periodEnd && (reloadCnt >= rateCfg);
  assign loadNow   = armed && (fullPoint || (halfEn && halfPoint));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadCnt <= '0;
      armed     <= 1'b0;
    end else begin
      if (periodEnd) reloadCnt <= fullPoint ? '0 : reloadCnt + 1'b1;
      if (wrHit(REG_ARM))  armed <= 1'b1;
      else if (loadNow)    armed <= 1'b0;
    end
  end

  // fault latching and safe-state control
  assign clrMask = wrHit(REG_FCLR) ? wrData[NUM_FAULTS-1:0] : '0;
  assign pairHit = |((faultLat | faultDet) & maskPair);
  assign xHit    = |((faultLat | faultDet) & maskX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultLat  <= '0;
      blockPair <= 1'b0;
      blockX    <= 1'b0;
    end else begin
      faultLat <= (faultLat & ~clrMask) | faultDet;
      if (pairHit)        blockPair <= 1'b1;
      else if (periodEnd) blockPair <= 1'b0;
      if (xHit)           blockX    <= 1'b1;
      else if (periodEnd) blockX    <= 1'b0;
    end
  end

  always_comb begin
    strb.loadAct    = loadNow;
    strb.applyForce = forceStrobe;
    strb.blockPair  = blockPair;
    strb.blockX     = blockX;
  end

endmodule

// File: rtl/pwm_fg_datapath.sv
module pwm_fg_datapath
  import pwm_fg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [CNT_W-1:0]  periodSh,
  input  logic [CNT_W-1:0]  dutyASh,
  input  logic [CNT_W-1:0]  dutyXSh,
  input  logic [NUM_CH-1:0] polSh,
  input  logic [NUM_CH-1:0] swEnSh,
  input  logic [NUM_CH-1:0] swValSh,
  output logic              periodEnd,
  output logic              halfPoint,
  output logic [NUM_CH-1:0] outBits,
  output logic [CNT_W-1:0]  dutyAAct,
  output logic [NUM_CH-1:0] polAct,
  output logic [NUM_CH-1:0] swEnAct
);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  periodAct;
  logic [CNT_W-1:0]  dutyXAct;
  logic [NUM_CH-1:0] swValAct;
  logic [NUM_CH-1:0] rawBits;
  logic [NUM_CH-1:0] chBlock;
  logic [NUM_CH-1:0] nxtBits;

  // the >= also recovers when a midpoint reload shrinks the period
  assign periodEnd = cnt >= periodAct;
  assign halfPoint = cnt == (periodAct >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else       cnt <= periodEnd ? '0 : cnt + 1'b1;
  end

  // active copies of the double-buffered values
  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodAct <= '0;
      dutyAAct  <= '0;
      dutyXAct  <= '0;
    end else if (strb.loadAct) begin
      periodAct <= periodSh;
      dutyAAct  <= dutyASh;
      dutyXAct  <= dutyXSh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polAct   <= '0;
      swEnAct  <= '0;
      swValAct <= '0;
    end else if (strb.applyForce) begin
      polAct   <= polSh;
      swEnAct  <= swEnSh;
      swValAct <= swValSh;
    end
  end

  assign rawBits[CH_A] = cnt < dutyAAct;
  assign rawBits[CH_B] = ~rawBits[CH_A];
  assign rawBits[CH_X] = cnt < dutyXAct;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    if (ch == CH_X) begin : g_third
      assign chBlock[ch] = strb.blockX;
    end else begin : g_pair
      assign chBlock[ch] = strb.blockPair;
    end

    always_comb begin
      if (chBlock[ch])      nxtBits[ch] = polAct[ch];
      else if (swEnAct[ch]) nxtBits[ch] = swValAct[ch] ^ polAct[ch];
      else                  nxtBits[ch] = rawBits[ch] ^ polAct[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outBits <= '0;
    else       outBits <= nxtBits;
  end

endmodule

// File: rtl/pwm_fault_gen.sv
module pwm_fault_gen
  import pwm_fg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 16,
  parameter int NUM_FAULTS = 8,
  parameter int FILT_W     = 3,
  parameter int RATE_W     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [3:0]            wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_FAULTS-1:0] faultIn,
  input  logic                  forceStrobe,
  output logic                  outA,
  output logic                  outB,
  output logic                  outX
);

  dpStrobe_t         strb;
  logic [CNT_W-1:0]  periodSh;
  logic [CNT_W-1:0]  dutyASh;
  logic [CNT_W-1:0]  dutyXSh;
  logic [NUM_CH-1:0] polSh;
  logic [NUM_CH-1:0] swEnSh;
  logic [NUM_CH-1:0] swValSh;
  logic              periodEnd;
  logic              halfPoint;
  logic [NUM_CH-1:0] outBits;
  logic [CNT_W-1:0]  dutyAAct;
  logic [NUM_CH-1:0] polAct;
  logic [NUM_CH-1:0] swEnAct;
  logic              loadStrb;
  logic              pairSafe;
  logic              xSafe;

  pwm_fg_ctrl #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_FAULTS(NUM_FAULTS),
    .FILT_W(FILT_W), .RATE_W(RATE_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .faultIn    (faultIn),
    .forceStrobe(forceStrobe),
    .periodEnd  (periodEnd),
    .halfPoint  (halfPoint),
    .strb       (strb),
    .periodSh   (periodSh),
    .dutyASh    (dutyASh),
    .dutyXSh    (dutyXSh),
    .polSh      (polSh),
    .swEnSh     (swEnSh),
    .swValSh    (swValSh)
  );

  pwm_fg_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .periodSh (periodSh),
    .dutyASh  (dutyASh),
    .dutyXSh  (dutyXSh),
    .polSh    (polSh),
    .swEnSh   (swEnSh),
    .swValSh  (swValSh),
    .periodEnd(periodEnd),
    .halfPoint(halfPoint),
    .outBits  (outBits),
    .dutyAAct (dutyAAct),
    .polAct   (polAct),
    .swEnAct  (swEnAct)
  );

  assign loadStrb = strb.loadAct;
  assign pairSafe = strb.blockPair;
  assign xSafe    = strb.blockX;

  assign outA = outBits[CH_A];
  assign outB = outBits[CH_B];
  assign outX = outBits[CH_X];

endmodule

// File: rtl/pwm_fault_gen_chk.sv
module pwm_fault_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             forceStrobe,
  input logic             outA,
  input logic             outB,
  input logic             outX,
  input logic             loadStrb,
  input logic             pairSafe,
  input logic             xSafe,
  input logic             periodEnd,
  input logic [CNT_W-1:0] dutyAAct,
  input logic [2:0]       polAct,
  input logic [2:0]       swEnAct
);

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(loadStrb) |-> $stable(dutyAAct)); // R1

  AST_PAIR_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    pairSafe |=> (outA == $past(polAct[0]) && outB == $past(polAct[1]))); // R7

  AST_X_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    xSafe |=> (outX == $past(polAct[2]))); // R7

  AST_SAFE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (pairSafe && !periodEnd) |=> pairSafe); // R8

  AST_STAGED_UNTIL_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(forceStrobe) |-> ($stable(polAct) && $stable(swEnAct))); // R11

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    (!pairSafe && swEnAct[1:0] == 2'b00 && polAct[1:0] == 2'b00) |=> (outA != outB)); // R5

endmodule

bind pwm_fault_gen pwm_fault_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .forceStrobe(forceStrobe),
  .outA       (outA),
  .outB       (outB),
  .outX       (outX),
  .loadStrb   (loadStrb),
  .pairSafe   (pairSafe),
  .xSafe      (xSafe),
  .periodEnd  (periodEnd),
  .dutyAAct   (dutyAAct),
  .polAct     (polAct),
  .swEnAct    (swEnAct)
);

// File: tb/pwm_fault_gen_tb.sv
`timescale 1ns/1ps
module pwm_fault_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [7:0]  faultIn = '0;
  logic        forceStrobe = 1'b0;
  logic        outA, outB, outX;

  int nChecks = 0;
  int nFails  = 0;
  int hiA, hiB, hiX, eqAB;
  int pulseW;

  always #2.5 clk = ~clk;

  pwm_fault_gen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .faultIn(faultIn), .forceStrobe(forceStrobe),
    .outA(outA), .outB(outB), .outX(outX)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung, expected completion");
    report();
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseForce();
    forceStrobe = 1'b1;
    @(negedge clk);
    forceStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts highs over n consecutive samples
  task automatic sampleWindow(input int n);
    hiA = 0; hiB = 0; hiX = 0; eqAB = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hiA += int'(outA); hiB += int'(outB); hiX += int'(outX);
      eqAB += int'(outA == outB);
    end
  endtask

  // returns at the first sample where the chosen output is high after low
  task automatic waitRise(input int ch);
    logic prev, cur;
    prev = (ch == 0) ? outA : outX;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      cur = (ch == 0) ? outA : outX;
      if (!prev && cur) return;
      prev = cur;
    end
  endtask

  // measures the width of the next pulse on outA
  task automatic measureA();
    waitRise(0);
    pulseW = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (outA) pulseW++;
      else return;
    end
  endtask

  task automatic testReset();
    idle(4);
    checkEq("R12 outA in reset", int'(outA), 0);
    checkEq("R12 outB in reset", int'(outB), 0);
    checkEq("R12 outX in reset", int'(outX), 0);
    rstN = 1'b1;
    idle(3);
    checkEq("R12 outB after reset", int'(outB), 1);
    checkEq("R12 outA after reset", int'(outA), 0);
  endtask

  task automatic testBasic();
    writeReg(4'd0, 16'd9);
    writeReg(4'd1, 16'd3);
    writeReg(4'd2, 16'd6);
    writeReg(4'd3, 16'd0);
    writeReg(4'd4, 16'd1);
    idle(25);
    sampleWindow(10);
    checkEq("R5 outA high count", hiA, 3);
    checkEq("R5 outX high count", hiX, 6);
    checkEq("R5 outB high count", hiB, 7);
    checkEq("R5 pair equal samples", eqAB, 0);
  endtask

  task automatic testNoArm();
    writeReg(4'd1, 16'd7);
    idle(40);
    sampleWindow(10);
    checkEq("R4 unarmed duty kept", hiA, 3);
    writeReg(4'd4, 16'd1);
    idle(25);
    sampleWindow(10);
    checkEq("R4 armed duty applied", hiA, 7);
  endtask

  task automatic testReloadRate();
    int n5;
    bit bad;
    bad = 0;
    writeReg(4'd3, 16'd3);       // N = 4
    writeReg(4'd1, 16'd5);
    writeReg(4'd4, 16'd1);
    for (int i = 0; i < 12; i++) begin
      measureA();
      if (pulseW == 5) break;
      if (pulseW != 7) bad = 1;
    end
    checkEq("R1 new width reached", pulseW, 5);
    writeReg(4'd1, 16'd2);
    writeReg(4'd4, 16'd1);
    n5 = 1;
    for (int i = 0; i < 12; i++) begin
      measureA();
      if (pulseW == 5) n5++;
      else if (pulseW == 2) break;
      else bad = 1;
    end
    checkEq("R1 only whole pulses", int'(bad), 0);
    checkEq("R2 periods between reloads", n5, 4);
    checkEq("R2 second value applied", pulseW, 2);
    writeReg(4'd3, 16'd0);
  endtask

  task automatic testHalfReload();
    writeReg(4'd3, 16'h0100);    // N = 1, midpoint enabled
    writeReg(4'd1, 16'd3);
    writeReg(4'd4, 16'd1);
    idle(30);
    writeReg(4'd1, 16'd8);
    waitRise(0);
    writeReg(4'd4, 16'd1);       // armed early in the period
    measureA();
    checkEq("R3 mid-period pulse width", pulseW, 3);
    measureA();
    checkEq("R3 following full pulse", pulseW, 8);
    writeReg(4'd3, 16'd0);
  endtask

  task automatic testPolarityForce();
    writeReg(4'd1, 16'd6);
    writeReg(4'd2, 16'd4);
    writeReg(4'd4, 16'd1);
    idle(25);
    writeReg(4'd5, 16'h0001);
    idle(15);
    sampleWindow(10);
    checkEq("R9 staged polarity ignored", hiA, 6);
    pulseForce();
    idle(3);
    sampleWindow(10);
    checkEq("R9 inverted outA high count", hiA, 4);
    checkEq("R11 outB unchanged high count", hiB, 4);
    checkEq("R11 pair equal after force", eqAB, 10);
    writeReg(4'd5, 16'h0000);
    pulseForce();
    idle(3);
  endtask

  task automatic testOverride();
    writeReg(4'd6, 16'h0044);    // X override enabled, level 1
    idle(5);
    sampleWindow(10);
    checkEq("R10 staged override ignored", hiX, 4);
    pulseForce();
    idle(3);
    sampleWindow(10);
    checkEq("R10 outX held high", hiX, 10);
    checkEq("R10 outA still running", hiA, 6);
    writeReg(4'd6, 16'h0000);
    pulseForce();
    idle(3);
  endtask

  task automatic testFault();
    writeReg(4'd8, 16'd3);       // four samples needed
    writeReg(4'd7, 16'h0001);    // line 0 to the pair only
    faultIn[0] = 1'b1;
    idle(3);
    faultIn[0] = 1'b0;
    idle(15);
    sampleWindow(10);
    checkEq("R6 short pulse filtered", hiA, 6);
    faultIn[0] = 1'b1;
    idle(4);
    faultIn[0] = 1'b0;
    idle(5);
    sampleWindow(10);
    checkEq("R7 outA safe", hiA, 0);
    checkEq("R7 outB safe", hiB, 0);
    checkEq("R7 outX unaffected", hiX, 4);
    idle(30);
    sampleWindow(10);
    checkEq("R8 safe state latched", hiA + hiB, 0);
    waitRise(1);                 // counter just passed zero
    writeReg(4'd9, 16'h0001);
    measureA();
    checkEq("R8 first pulse whole", pulseW, 6);
    sampleWindow(10);
    checkEq("R8 outputs resumed", hiB, 4);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testBasic();
    testNoArm();
    testReloadRate();
    testHalfReload();
    testPolarityForce();
    testOverride();
    testFault();
    report();
  end

endmodule